// File: doc/BRIEF.md
# Compressed-Row Sparse Matrix Walker

This block walks a sparse matrix held in compressed-row form and turns it into a stream of matrix elements for a downstream multiply stage. For each row it reads two entries of the row-start table to find how many nonzeros the row holds. It then reads the value and column-index stores in address order and emits one element per cycle. Each element carries its value, its column index, the index of its row and a label that counts the elements of the row still to come. After the last element of a row the walker waits for the accumulator to report that the row sum is finished, and only then moves to the next row.

The value and column-index stores share one word address. Each word holds two consecutive entries, and the low half is the earlier one. A row with an odd number of nonzeros leaves the high half of its last word as padding, so every row starts on a new word. The stores answer after a fixed number of cycles set by `MEM_LAT`. A shift register of that depth carries each element's valid flag, label, row and half-select alongside the outstanding read.

The element stream has no ready signal. The downstream stage is a fixed-latency pipeline and must take every beat in the cycle `elem_valid` is high. Back-pressure is applied one level up, through the stall the walker keeps after every row until `acc_done` arrives.

Top module: `crs_row_walker`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `prog_end`, `elem_valid`, `empty_row_valid`, `ptr_rd_en` and `dat_rd_en` are all low.
- R2: A `start` pulse seen while idle captures `nnz_total` and `row_count` and raises `busy` in the next cycle. A `start` pulse or a change of those inputs while busy has no effect on the walk.
- R3: The length of row r is table[r+1] minus table[r]. For the last row it is `nnz_total` minus table[row_count-1]. The entry table[row_count] is never read. The table answers one cycle after `ptr_rd_en`.
- R4: Elements leave in storage order. Word addresses start at 0 and step by one per word. The earlier entry of a word sits in bits [VAL_W-1:0] and [COL_W-1:0], and the later one in the upper halves. Each row begins on a fresh word, and the upper half of an odd row's last word is never emitted.
- R5: Each element's `elem_label` is the number of elements of its row not yet emitted, counting itself: the first element carries the row length and the last carries 1. `elem_row` gives the row index.
- R6: The elements of one row leave in consecutive cycles, with no gap.
- R7: After a row's elements have been read, no table or data read is issued until `acc_done` is sampled high. An `acc_done` pulse while the row's reads are still being issued is ignored.
- R8: A row of length zero produces no element and no wait for `acc_done`. It produces a one-cycle `empty_row_valid` with `empty_row_idx` equal to the row index.
- R9: After the last row, `prog_end` is high for one cycle and `busy` is low in that same cycle. With `row_count` of 0, `prog_end` follows `start` at once and no table read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (idle only) |
| nnz_total | input | NZ_W | Total nonzero count of the matrix |
| row_count | input | ROW_W | Number of rows |
| busy | output | 1 | High while a walk is in progress |
| prog_end | output | 1 | One-cycle pulse when the walk completes |
| ptr_rd_en | output | 1 | Row-start table read request |
| ptr_rd_addr | output | ROW_W | Row-start table index |
| ptr_rd_data | input | NZ_W | Row-start table entry, one cycle after request |
| dat_rd_en | output | 1 | Value/column word read request |
| dat_rd_addr | output | NZ_W | Value/column word address |
| dat_rd_val | input | 2*VAL_W | Two packed values, MEM_LAT cycles after request |
| dat_rd_col | input | 2*COL_W | Two packed column indices, same timing |
| acc_done | input | 1 | Accumulator finished the current row |
| elem_valid | output | 1 | Element beat present |
| elem_val | output | VAL_W | Matrix value |
| elem_col | output | COL_W | Column index |
| elem_label | output | NZ_W | Elements of the row remaining, counting this one |
| elem_row | output | ROW_W | Row index of the element |
| empty_row_valid | output | 1 | One-cycle pulse for a zero-length row |
| empty_row_idx | output | ROW_W | Index of that row |

## Verification
The bench builds the walker with 16-bit values, 8-bit columns, 4-bit row indices, 8-bit counts and a store latency of 2. With that latency, returning elements overlap the issue phase for rows of four or more elements. This allows `acc_done` pulses to land while reads are still being issued, and so the bench can show that those pulses are ignored. Thirteen matrices are swept, with up to six rows, row lengths from 0 to 7 and a zero-row case. Together they cover even and odd rows, padded words, and empty first, middle and last rows. A junk entry placed after the table's end exposes any read past the last row.

// File: rtl/crs_walk_pkg.sv
package crs_walk_pkg;
  typedef enum logic [1:0] {WK_IDLE, WK_PTR, WK_DATA, WK_HOLD} wk_state_e;
  typedef enum logic [1:0] {PS_ROW, PS_NEXT, PS_LEN} ptr_step_e;
endpackage

// File: rtl/crs_row_len.sv
module crs_row_len #(
  parameter int NZ_W = 20
) (
  input  logic [NZ_W-1:0] cur_ptr,
  input  logic [NZ_W-1:0] nxt_ptr,
  input  logic [NZ_W-1:0] nnz,
  input  logic            last,
  output logic [NZ_W-1:0] len,
  output logic            empty
);
  logic [NZ_W-1:0] end_ptr;

  // the final row ends at the total count, not at a table entry
  assign end_ptr = last ? nnz : nxt_ptr;
  assign len     = end_ptr - cur_ptr;
  assign empty   = (len == '0);
endmodule

// File: rtl/crs_walk_fsm.sv
module crs_walk_fsm
  import crs_walk_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int NZ_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NZ_W-1:0]  nnz_total,
  input  logic [ROW_W-1:0] row_count,
  input  logic             acc_done,
  input  logic [NZ_W-1:0]  ptr_rd_data,
  output logic             busy,
  output logic             prog_end,
  output logic             ptr_rd_en,
  output logic [ROW_W-1:0] ptr_rd_addr,
  output logic             dat_rd_en,
  output logic [NZ_W-1:0]  dat_rd_addr,
  output logic             iss_valid,
  output logic             iss_half,
  output logic [NZ_W-1:0]  iss_label,
  output logic [ROW_W-1:0] iss_row,
  output logic             empty_valid,
  output logic [ROW_W-1:0] empty_idx
);
  wk_state_e        state;
  ptr_step_e        step;
  logic [ROW_W-1:0] nrows_q, row_q;
  logic [NZ_W-1:0]  nnz_q, cur_ptr_q, len_q, idx_q, waddr_q;
  logic             prog_end_q, empty_q;
  logic [ROW_W-1:0] empty_idx_q;
  logic             last_row;
  logic [NZ_W-1:0]  row_len;
  logic             row_empty;

  assign last_row = (row_q == nrows_q - 1'b1);

  crs_row_len #(.NZ_W(NZ_W)) u_len (
    .cur_ptr (cur_ptr_q),
    .nxt_ptr (ptr_rd_data),
    .nnz     (nnz_q),
    .last    (last_row),
    .len     (row_len),
    .empty   (row_empty)
  );

  // table reads: own entry first, then the next one unless this is the last row
  assign ptr_rd_en   = (state == WK_PTR) &&
                       ((step == PS_ROW) || ((step == PS_NEXT) && !last_row));
  assign ptr_rd_addr = (step == PS_NEXT) ? row_q + 1'b1 : row_q;

  // one word read serves an even element and the odd one after it
  assign dat_rd_en   = (state == WK_DATA) && !idx_q[0];
  assign dat_rd_addr = waddr_q;

  assign iss_valid   = (state == WK_DATA);
  assign iss_half    = idx_q[0];
  assign iss_label   = len_q - idx_q;
  assign iss_row     = row_q;

  assign busy        = (state != WK_IDLE);
  assign prog_end    = prog_end_q;
  assign empty_valid = empty_q;
  assign empty_idx   = empty_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= WK_IDLE;
      step        <= PS_ROW;
      nrows_q     <= '0;
      row_q       <= '0;
      nnz_q       <= '0;
      cur_ptr_q   <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      waddr_q     <= '0;
      prog_end_q  <= 1'b0;
      empty_q     <= 1'b0;
      empty_idx_q <= '0;
    end else begin
      prog_end_q <= 1'b0;
      empty_q    <= 1'b0;
      case (state)
        WK_IDLE: begin
          if (start) begin
            nrows_q <= row_count;
            nnz_q   <= nnz_total;
            row_q   <= '0;
            waddr_q <= '0;
            step    <= PS_ROW;
            if (row_count == '0) prog_end_q <= 1'b1;
            else                 state      <= WK_PTR;
          end
        end
        WK_PTR: begin
          case (step)
            PS_ROW:  step <= PS_NEXT;
            PS_NEXT: begin
              cur_ptr_q <= ptr_rd_data;
              step      <= PS_LEN;
            end
            default: begin
              step <= PS_ROW;
              if (row_empty) begin
                empty_q     <= 1'b1;
                empty_idx_q <= row_q;
                if (last_row) begin
                  state      <= WK_IDLE;
                  prog_end_q <= 1'b1;
                end else begin
                  row_q <= row_q + 1'b1;
                end
              end else begin
                len_q <= row_len;
                idx_q <= '0;
                state <= WK_DATA;
              end
            end
          endcase
        end
        WK_DATA: begin
          idx_q <= idx_q + 1'b1;
          if (!idx_q[0]) waddr_q <= waddr_q + 1'b1;
          if (idx_q == len_q - 1'b1) state <= WK_HOLD;
        end
        default: begin
          if (acc_done) begin
            if (last_row) begin
              state      <= WK_IDLE;
              prog_end_q <= 1'b1;
            end else begin
              row_q <= row_q + 1'b1;
              step  <= PS_ROW;
              state <= WK_PTR;
            end
          end
        end
      endcase
    end
  end

  // R7
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WK_HOLD && !acc_done) |=> (state == WK_HOLD));

  // R2
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(nrows_q) && $stable(nnz_q)));

  // R3
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd_en |-> (ptr_rd_addr < nrows_q));

  // R4
  word_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd_en |=> !dat_rd_en);

  // R9
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_end |-> !busy);
endmodule

// File: rtl/crs_beat_align.sv
module crs_beat_align #(
  parameter int VAL_W = 32,
  parameter int COL_W = 16,
  parameter int ROW_W = 16,
  parameter int NZ_W  = 20,
  parameter int LAT   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  input  logic               iss_half,
  input  logic [NZ_W-1:0]    iss_label,
  input  logic [ROW_W-1:0]   iss_row,
  input  logic [2*VAL_W-1:0] dat_rd_val,
  input  logic [2*COL_W-1:0] dat_rd_col,
  output logic               elem_valid,
  output logic [VAL_W-1:0]   elem_val,
  output logic [COL_W-1:0]   elem_col,
  output logic [NZ_W-1:0]    elem_label,
  output logic [ROW_W-1:0]   elem_row
);
  localparam int TAIL = LAT - 1;

  logic [LAT-1:0]            trk_v, trk_h;
  logic [LAT-1:0][NZ_W-1:0]  trk_lab;
  logic [LAT-1:0][ROW_W-1:0] trk_row;
  logic [VAL_W-1:0]          hi_val_q;
  logic [COL_W-1:0]          hi_col_q;
  logic                      tail_v, tail_h;

  assign tail_v = trk_v[TAIL];
  assign tail_h = trk_h[TAIL];

  // tracking line matched to the store latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_v   <= '0;
      trk_h   <= '0;
      trk_lab <= '0;
      trk_row <= '0;
    end else begin
      trk_v[0]   <= iss_valid;
      trk_h[0]   <= iss_half;
      trk_lab[0] <= iss_label;
      trk_row[0] <= iss_row;
      for (int s = 1; s < LAT; s++) begin
        trk_v[s]   <= trk_v[s-1];
        trk_h[s]   <= trk_h[s-1];
        trk_lab[s] <= trk_lab[s-1];
        trk_row[s] <= trk_row[s-1];
      end
    end
  end

  // low half goes out at once, high half is parked for the next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_val_q   <= '0;
      hi_col_q   <= '0;
      elem_valid <= 1'b0;
      elem_val   <= '0;
      elem_col   <= '0;
      elem_label <= '0;
      elem_row   <= '0;
    end else begin
      elem_valid <= tail_v;
      if (tail_v) begin
        elem_label <= trk_lab[TAIL];
        elem_row   <= trk_row[TAIL];
        if (tail_h) begin
          elem_val <= hi_val_q;
          elem_col <= hi_col_q;
        end else begin
          elem_val <= dat_rd_val[VAL_W-1:0];
          elem_col <= dat_rd_col[COL_W-1:0];
          hi_val_q <= dat_rd_val[2*VAL_W-1:VAL_W];
          hi_col_q <= dat_rd_col[2*COL_W-1:COL_W];
        end
      end
    end
  end

  // R5
  label_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> (elem_label != '0));

  // R6
  label_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && elem_label > 1) |=> (elem_valid && elem_label == $past(elem_label) - 1'b1));

  // R4
  half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_v && tail_h) |-> $past(tail_v && !tail_h));
endmodule

// File: rtl/crs_row_walker.sv
module crs_row_walker #(
  parameter int VAL_W   = 32,
  parameter int COL_W   = 16,
  parameter int ROW_W   = 16,
  parameter int NZ_W    = 20,
  parameter int MEM_LAT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NZ_W-1:0]    nnz_total,
  input  logic [ROW_W-1:0]   row_count,
  output logic               busy,
  output logic               prog_end,
  output logic               ptr_rd_en,
  output logic [ROW_W-1:0]   ptr_rd_addr,
  input  logic [NZ_W-1:0]    ptr_rd_data,
  output logic               dat_rd_en,
  output logic [NZ_W-1:0]    dat_rd_addr,
  input  logic [2*VAL_W-1:0] dat_rd_val,
  input  logic [2*COL_W-1:0] dat_rd_col,
  input  logic               acc_done,
  output logic               elem_valid,
  output logic [VAL_W-1:0]   elem_val,
  output logic [COL_W-1:0]   elem_col,
  output logic [NZ_W-1:0]    elem_label,
  output logic [ROW_W-1:0]   elem_row,
  output logic               empty_row_valid,
  output logic [ROW_W-1:0]   empty_row_idx
);
  logic             iss_valid, iss_half;
  logic [NZ_W-1:0]  iss_label;
  logic [ROW_W-1:0] iss_row;

  crs_walk_fsm #(.ROW_W(ROW_W), .NZ_W(NZ_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .nnz_total   (nnz_total),
    .row_count   (row_count),
    .acc_done    (acc_done),
    .ptr_rd_data (ptr_rd_data),
    .busy        (busy),
    .prog_end    (prog_end),
    .ptr_rd_en   (ptr_rd_en),
    .ptr_rd_addr (ptr_rd_addr),
    .dat_rd_en   (dat_rd_en),
    .dat_rd_addr (dat_rd_addr),
    .iss_valid   (iss_valid),
    .iss_half    (iss_half),
    .iss_label   (iss_label),
    .iss_row     (iss_row),
    .empty_valid (empty_row_valid),
    .empty_idx   (empty_row_idx)
  );

  crs_beat_align #(
    .VAL_W(VAL_W), .COL_W(COL_W), .ROW_W(ROW_W), .NZ_W(NZ_W), .LAT(MEM_LAT)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_half   (iss_half),
    .iss_label  (iss_label),
    .iss_row    (iss_row),
    .dat_rd_val (dat_rd_val),
    .dat_rd_col (dat_rd_col),
    .elem_valid (elem_valid),
    .elem_val   (elem_val),
    .elem_col   (elem_col),
    .elem_label (elem_label),
    .elem_row   (elem_row)
  );
endmodule

// File: tb/crs_row_walker_bench.sv
module crs_row_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 16;
  localparam int CW = 8;
  localparam int RW = 4;
  localparam int NW = 8;
  localparam int LAT = 2;
  localparam int HOLD_DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NW-1:0] nnz_total = '0;
  logic [RW-1:0] row_count = '0;
  logic busy, prog_end, ptr_rd_en, dat_rd_en;
  logic [RW-1:0] ptr_rd_addr;
  logic [NW-1:0] ptr_rd_data;
  logic [NW-1:0] dat_rd_addr;
  logic [2*VW-1:0] dat_rd_val;
  logic [2*CW-1:0] dat_rd_col;
  logic acc_done = 1'b0;
  logic elem_valid, empty_row_valid;
  logic [VW-1:0] elem_val;
  logic [CW-1:0] elem_col;
  logic [NW-1:0] elem_label;
  logic [RW-1:0] elem_row, empty_row_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  crs_row_walker #(.VAL_W(VW), .COL_W(CW), .ROW_W(RW), .NZ_W(NW), .MEM_LAT(LAT)) u_crs_row_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .nnz_total(nnz_total), .row_count(row_count),
    .busy(busy), .prog_end(prog_end), .ptr_rd_en(ptr_rd_en), .ptr_rd_addr(ptr_rd_addr),
    .ptr_rd_data(ptr_rd_data), .dat_rd_en(dat_rd_en), .dat_rd_addr(dat_rd_addr),
    .dat_rd_val(dat_rd_val), .dat_rd_col(dat_rd_col), .acc_done(acc_done),
    .elem_valid(elem_valid), .elem_val(elem_val), .elem_col(elem_col),
    .elem_label(elem_label), .elem_row(elem_row),
    .empty_row_valid(empty_row_valid), .empty_row_idx(empty_row_idx)
  );

  // memory models
  logic [NW-1:0]   ptr_mem [0:15];
  logic [2*VW-1:0] wv [0:255];
  logic [2*CW-1:0] wc [0:255];
  logic [2*VW-1:0] vpipe [0:LAT-1];
  logic [2*CW-1:0] cpipe [0:LAT-1];

  always @(posedge clk) begin
    ptr_rd_data <= ptr_mem[ptr_rd_addr];
    vpipe[0] <= dat_rd_en ? wv[dat_rd_addr] : '0;
    cpipe[0] <= dat_rd_en ? wc[dat_rd_addr] : '0;
    for (int s = 1; s < LAT; s++) begin
      vpipe[s] <= vpipe[s-1];
      cpipe[s] <= cpipe[s-1];
    end
  end
  assign dat_rd_val = vpipe[LAT-1];
  assign dat_rd_col = cpipe[LAT-1];

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int exp_val [0:63];
  int exp_col [0:63];
  int exp_lab [0:63];
  int exp_row [0:63];
  int exp_first [0:63];
  int exp_empty [0:15];
  int exp_n, exp_ne, cur_nrows, cur_nnz;

  task automatic build(input int m, input int nr);
    int e, w, l, v, c, word;
    for (int k = 0; k < 256; k++) begin
      wv[k] = '0;
      wc[k] = '0;
    end
    for (int k = 0; k < 16; k++) ptr_mem[k] = '1;
    e = 0; w = 0; exp_ne = 0;
    for (int r = 0; r < nr; r++) begin
      ptr_mem[r] = NW'(e);
      l = (r*5 + m*3 + m/2) % 8;
      if (l == 0) begin
        exp_empty[exp_ne] = r;
        exp_ne++;
      end
      for (int i = 0; i < l; i++) begin
        v = (e*37 + m*11 + 1) & 16'hFFFF;
        c = (r*13 + i*7 + m) & 8'hFF;
        word = w + i/2;
        if (i % 2 == 0) begin
          wv[word][VW-1:0] = VW'(v);
          wc[word][CW-1:0] = CW'(c);
        end else begin
          wv[word][2*VW-1:VW] = VW'(v);
          wc[word][2*CW-1:CW] = CW'(c);
        end
        exp_val[e] = v; exp_col[e] = c; exp_lab[e] = l - i;
        exp_row[e] = r; exp_first[e] = (i == 0) ? 1 : 0;
        e++;
      end
      w += (l + 1) / 2;
    end
    exp_n = e;
    cur_nrows = nr;
    cur_nnz = e;
  endtask

  // monitor and accumulator stand-in
  bit mon_on = 1'b0;
  int bi, ei, hold_cnt, ptr_reads, pe_cnt;
  bit prev_v;

  always @(negedge clk) begin
    acc_done = 1'b0;
    if (mon_on) begin
      if (hold_cnt > 0) begin
        // R7: stalled until acc_done
        chk(!ptr_rd_en && !dat_rd_en, "R7 read during stall", int'(ptr_rd_en) + int'(dat_rd_en), 0);
        if (hold_cnt == 1) acc_done = 1'b1;
        hold_cnt--;
      end
      if (elem_valid) begin
        if (bi >= exp_n) begin
          chk(1'b0, "R4 extra element", bi, exp_n);
        end else begin
          chk(int'(elem_val) == exp_val[bi], "R4 value", int'(elem_val), exp_val[bi]);
          chk(int'(elem_col) == exp_col[bi], "R4 column", int'(elem_col), exp_col[bi]);
          chk(int'(elem_label) == exp_lab[bi], "R5 label", int'(elem_label), exp_lab[bi]);
          chk(int'(elem_row) == exp_row[bi], "R5 row", int'(elem_row), exp_row[bi]);
          if (exp_first[bi] == 0) chk(prev_v, "R6 gap inside row", int'(prev_v), 1);
          if (exp_lab[bi] == 1) hold_cnt = HOLD_DLY;
          // R7: stray done pulse while the row is still being read
          if (exp_lab[bi] >= 4) acc_done = 1'b1;
        end
        bi++;
      end
      if (empty_row_valid) begin
        if (ei >= exp_ne) chk(1'b0, "R8 extra empty row", ei, exp_ne);
        else chk(int'(empty_row_idx) == exp_empty[ei], "R8 empty row index", int'(empty_row_idx), exp_empty[ei]);
        ei++;
      end
      if (ptr_rd_en) begin
        ptr_reads++;
        chk(int'(ptr_rd_addr) < cur_nrows, "R3 table read past end", int'(ptr_rd_addr), cur_nrows - 1);
      end
      if (prog_end) begin
        pe_cnt++;
        chk(!busy, "R9 busy at prog_end", int'(busy), 0);
      end
      prev_v = elem_valid;
    end
  end

  task automatic run(input int m, input int nr, input bit extra);
    int t;
    build(m, nr);
    bi = 0; ei = 0; hold_cnt = 0; ptr_reads = 0; pe_cnt = 0; prev_v = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1; row_count = RW'(nr); nnz_total = NW'(cur_nnz);
    @(negedge clk);
    start = 1'b0;
    chk(busy == (nr != 0), "R2 busy after start", int'(busy), int'(nr != 0));
    if (extra) begin
      repeat (3) @(negedge clk);
      start = 1'b1; row_count = '0; nnz_total = '0;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (pe_cnt == 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 2000, "R9 walk timeout", t, 2000);
    repeat (4) @(negedge clk);
    chk(bi == exp_n, "R4 element count", bi, exp_n);
    chk(ei == exp_ne, "R8 empty row count", ei, exp_ne);
    chk(pe_cnt == 1, "R9 prog_end count", pe_cnt, 1);
    chk(!busy, "R9 idle after walk", int'(busy), 0);
    if (nr == 0) chk(ptr_reads == 0, "R9 table read with no rows", ptr_reads, 0);
    if (extra) chk(pe_cnt == 1, "R2 restart while busy", pe_cnt, 1);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !prog_end && !elem_valid && !empty_row_valid && !ptr_rd_en && !dat_rd_en,
        "R1 outputs in reset", int'(busy) + int'(elem_valid) + int'(ptr_rd_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !prog_end && !elem_valid && !ptr_rd_en && !dat_rd_en,
        "R1 outputs after reset", int'(busy) + int'(elem_valid) + int'(ptr_rd_en), 0);
    for (int m = 0; m < 12; m++) run(m, 1 + m % 6, m == 5);
    run(12, 0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule